// File: doc/BRIEF.md
# Vectored Fast-Interrupt Handshake Unit

This unit sits between an interrupt controller's pending logic and the processor. For every input it keeps one delivery-mode bit and one 32-bit handler address. Each cycle it takes the pending and enable vectors and picks the winning input, which is the lowest set index of their AND. If the winner is marked for fast delivery and no fast request is already in progress, the unit raises the interrupt request and drives that input's handler address on a separate address output. The processor can then branch straight to the handler.

A fast request holds until the processor pulses its acknowledge. On that acknowledge the unit emits a one-cycle, one-hot clear toward the pending logic for the serviced input. It drops the request and the address on the next cycle. If the winner uses normal delivery, the unit raises the request with a zero address and leaves retirement to software elsewhere. A small write port loads the mode bits and the address table. The number of inputs is a parameter of at most 32.

Top module: `fastvec_unit`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_addr_o` is 0 and `clr_o` is 0. All mode bits are 0 and every address-table entry is 0. A fast request on an input whose entry was never written therefore presents address 0.
- R2: A write with `wr_en_i`=1 and `wr_sel_i`=0 loads the mode bits from `wr_data_i[N_IN-1:0]`; bit i set means input i uses fast delivery. A write with `wr_en_i`=1 and `wr_sel_i`=1 loads table entry `wr_idx_i` with `wr_data_i`. Both writes take effect from the next cycle.
- R3: The winner is the lowest index i with `pend_i[i]` and `en_i[i]` both 1. Inputs that are not enabled never win.
- R4: The unit may be idle, with no fast request outstanding, and have a winner in fast mode at a clock edge. In that case `irq_o` is 1 and `vec_addr_o` equals the winner's table entry from that edge on.
- R5: While a fast request is outstanding, `irq_o` and `vec_addr_o` stay unchanged until the acknowledge is sampled. This holds even if the pending and enable vectors change or the held table entry is rewritten.
- R6: An `ack_i` pulse while a fast request is outstanding drives `clr_o` to the one-hot code of the serviced input in that same cycle. From the next edge, `irq_o` and `vec_addr_o` are 0.
- R7: An `ack_i` pulse while no fast request is outstanding is ignored. `clr_o` stays 0, and `irq_o` and `vec_addr_o` follow as if no acknowledge had arrived.
- R8: After an acknowledge, `irq_o` stays 0 for at least one full cycle. Only then can it rise again for the next winner.
- R9: The unit may be idle with a winner in normal mode at a clock edge. In that case `irq_o` is 1 and `vec_addr_o` is 0 for the following cycle. If no input is pending and enabled at that edge, `irq_o` is 0 for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_IN | Pending bits from the detection logic |
| en_i | input | N_IN | Per-input enable bits |
| ack_i | input | 1 | Processor acknowledge pulse for a fast request |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: mode bits, 1: address-table entry |
| wr_idx_i | input | IDXW | Table entry index for a table write |
| wr_data_i | input | AW | Write data |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_addr_o | output | AW | Handler address of the fast request, 0 otherwise |
| clr_o | output | N_IN | One-hot pending clear, valid in the acknowledge cycle |

## Verification
The request and address are registered, so they are due one edge after the inputs that cause them. Writes to mode and table bits only affect decisions from the edge after they land. The clear is combinational on the acknowledge and is due in the same cycle. The bench drives inputs at the falling edge and compares all three outputs against a behavioural model shortly afterward. It advances the model only at the rising edge, using the inputs it has just driven, so every output is compared in exactly the cycle its requirement names.

// File: rtl/fastvec_pkg.sv
package fastvec_pkg;
  typedef enum logic {
    FV_IDLE = 1'b0,
    FV_HOLD = 1'b1
  } fv_state_e;
endpackage

// File: rtl/fastvec_regs.sv
module fastvec_regs #(
  parameter int N_IN = 8,
  parameter int AW   = 32,
  localparam int IDXW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [IDXW-1:0]         wr_idx,
  input  logic [AW-1:0]           wr_data,
  output logic [N_IN-1:0]         mode_o,
  output logic [N_IN-1:0][AW-1:0] tbl_o
);
  logic [N_IN-1:0] mode_q, mode_d;
  logic            mode_we;

  assign mode_we = wr_en & ~wr_sel;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = wr_data[N_IN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  for (genvar g = 0; g < N_IN; g++) begin : g_ent
    logic [AW-1:0] ent_q, ent_d;
    logic          ent_we;

    assign ent_we = wr_en & wr_sel & (wr_idx == IDXW'(g));

    always_comb begin
      ent_d = ent_q;
      if (ent_we) ent_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign tbl_o[g] = ent_q;
  end
endmodule

// File: rtl/fastvec_pick.sv
module fastvec_pick #(
  parameter int N_IN = 8,
  localparam int IDXW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0] req,
  output logic            valid,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end

  assign valid = |req;
endmodule

// File: rtl/fastvec_hs.sv
module fastvec_hs
  import fastvec_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int AW   = 32,
  localparam int IDXW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_valid,
  input  logic [IDXW-1:0] win_idx,
  input  logic            win_fast,
  input  logic [AW-1:0]   win_addr,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [AW-1:0]   vec_addr_o,
  output logic [N_IN-1:0] clr_o,
  output logic            hold_o
);
  fv_state_e       state_q, state_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic            norm_q, norm_d;
  logic            ack_take;

  assign ack_take = (state_q == FV_HOLD) & ack_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    addr_d  = addr_q;
    norm_d  = 1'b0;
    if (state_q == FV_HOLD) begin
      if (ack_i) begin
        state_d = FV_IDLE;
        addr_d  = '0;
      end
    end else if (win_valid && win_fast) begin
      state_d = FV_HOLD;
      idx_d   = win_idx;
      addr_d  = win_addr;
    end else begin
      norm_d  = win_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FV_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      norm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      addr_q  <= addr_d;
      norm_q  <= norm_d;
    end
  end

  assign clr_o      = ack_take ? (N_IN'(1) << idx_q) : '0;
  assign hold_o     = (state_q == FV_HOLD);
  assign irq_o      = hold_o | norm_q;
  assign vec_addr_o = addr_q;
endmodule

// File: rtl/fastvec_unit.sv
module fastvec_unit #(
  parameter int N_IN = 8,   // at most 32
  parameter int AW   = 32,
  localparam int IDXW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] pend_i,
  input  logic [N_IN-1:0] en_i,
  input  logic            ack_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic [AW-1:0]   wr_data_i,
  output logic            irq_o,
  output logic [AW-1:0]   vec_addr_o,
  output logic [N_IN-1:0] clr_o
);
  logic [N_IN-1:0]         mode_w;
  logic [N_IN-1:0][AW-1:0] tbl_w;
  logic                    win_valid;
  logic [IDXW-1:0]         win_idx;
  logic                    hold_w;

  fastvec_regs #(.N_IN(N_IN), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .wr_sel(wr_sel_i), .wr_idx(wr_idx_i), .wr_data(wr_data_i),
    .mode_o(mode_w), .tbl_o(tbl_w)
  );

  fastvec_pick #(.N_IN(N_IN)) u_pick (
    .req(pend_i & en_i), .valid(win_valid), .idx(win_idx)
  );

  fastvec_hs #(.N_IN(N_IN), .AW(AW)) u_hs (
    .clk(clk), .rst_n(rst_n),
    .win_valid(win_valid), .win_idx(win_idx),
    .win_fast(mode_w[win_idx]), .win_addr(tbl_w[win_idx]),
    .ack_i(ack_i),
    .irq_o(irq_o), .vec_addr_o(vec_addr_o), .clr_o(clr_o), .hold_o(hold_w)
  );
endmodule

// File: rtl/fastvec_chk.sv
module fastvec_chk #(
  parameter int N_IN = 8,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_i,
  input logic            irq_o,
  input logic [AW-1:0]   vec_addr_o,
  input logic [N_IN-1:0] clr_o,
  input logic            hold
);
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o)); // R6
  AST_CLR_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> (ack_i && hold)); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ack_i) |=> (hold && irq_o && $stable(vec_addr_o))); // R5
  AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && ack_i) |=> (!irq_o && vec_addr_o == '0)); // R8
  AST_ADDR_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (vec_addr_o == '0)); // R9
endmodule

bind fastvec_unit fastvec_chk #(.N_IN(N_IN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .irq_o(irq_o),
  .vec_addr_o(vec_addr_o), .clr_o(clr_o), .hold(hold_w)
);

// File: tb/fastvec_unit_test.sv
module fastvec_unit_test;
  localparam int N  = 8;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pend_i, en_i;
  logic          ack_i, wr_en_i, wr_sel_i;
  logic [2:0]    wr_idx_i;
  logic [AW-1:0] wr_data_i;
  logic          irq_o;
  logic [AW-1:0] vec_addr_o;
  logic [N-1:0]  clr_o;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_tbl [N];
  logic [N-1:0]  m_mode;
  bit            m_hold, m_norm;
  int            m_idx;
  logic [AW-1:0] m_addr;

  always #4 clk = ~clk;

  fastvec_unit #(.N_IN(N), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .ack_i(ack_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .irq_o(irq_o), .vec_addr_o(vec_addr_o), .clr_o(clr_o)
  );

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_tbl[i] = '0;
    m_mode = '0; m_hold = 0; m_norm = 0; m_idx = 0; m_addr = '0;
  endtask

  task automatic model_edge();
    int win;
    win = -1;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && en_i[i]) begin win = i; break; end
    end
    if (m_hold) begin
      m_norm = 0;
      if (ack_i) begin m_hold = 0; m_addr = '0; end
    end else if (win >= 0 && m_mode[win]) begin
      m_hold = 1; m_idx = win; m_addr = m_tbl[win]; m_norm = 0;
    end else begin
      m_norm = (win >= 0);
    end
    if (wr_en_i && !wr_sel_i) m_mode = wr_data_i[N-1:0];
    if (wr_en_i && wr_sel_i && wr_idx_i < N) m_tbl[wr_idx_i] = wr_data_i;
  endtask

  task automatic step(input string tag);
    logic [N-1:0] eclr;
    #1;
    eclr = (m_hold && ack_i) ? N'(1 << m_idx) : '0;
    chk(tag, "irq_o", AW'(irq_o), AW'(m_hold || m_norm));
    chk(tag, "vec_addr_o", vec_addr_o, m_addr);
    chk(tag, "clr_o", AW'(clr_o), AW'(eclr));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en_i = 0; ack_i = 0;
  endtask

  task automatic wr(input bit sel, input int idx, input logic [AW-1:0] d, input string tag);
    wr_en_i = 1; wr_sel_i = sel; wr_idx_i = idx[2:0]; wr_data_i = d;
    step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; pend_i = '0; en_i = '1; ack_i = 0;
    wr_en_i = 0; wr_sel_i = 0; wr_idx_i = '0; wr_data_i = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1"); step("R1");

    // R1: fast on input 2 with never-written entry gives address 0
    wr(0, 0, 32'h0000_0004, "R2");
    pend_i = 8'h04; step("R1"); step("R4"); step("R5");
    ack_i = 1; step("R6");
    pend_i = 8'h00; step("R8"); step("R8");

    // R2: load table and mode 0,2,5,7 fast
    for (int i = 0; i < N; i++) wr(1, i, 32'h1000_0000 + 32'(i * 16), "R2");
    wr(0, 0, 32'h0000_00A5, "R2");

    // R3/R4: 5 and 7 pending, 5 wins
    pend_i = 8'hA0; step("R3"); step("R4");
    // R5: higher-priority normal input and table rewrite during hold
    pend_i = 8'hA8; step("R5");
    wr(1, 5, 32'hDEAD_0000, "R5"); step("R5");
    // R6: acknowledge
    ack_i = 1; step("R6");
    pend_i = 8'h88; step("R8");
    // R9: normal winner 3, ack ignored (R7)
    step("R9"); ack_i = 1; step("R7"); step("R7");
    // R3: disable 3 so 7 wins (fast)
    en_i = 8'hF7; step("R3"); step("R4");
    ack_i = 1; step("R6");
    pend_i = 8'h00; en_i = '1; step("R9"); step("R9");

    // R8: back-to-back fast inputs 0 and 2
    pend_i = 8'h05; step("R4"); step("R4");
    ack_i = 1; step("R6");
    pend_i = 8'h04; step("R8"); step("R8"); step("R5");
    ack_i = 1; step("R6");
    pend_i = 8'h00; step("R8");
    // R7: ack with nothing outstanding
    ack_i = 1; step("R7"); step("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule